// File: doc/BRIEF.md
# Multiply-Accumulate Operator

This block multiplies two 16-bit unsigned operands on every enabled clock edge and folds the 32-bit product into a running total. The total lives in a 32-bit sum register, with one further flip-flop above it that keeps the adder's carry-out. The two together form a 33-bit result. An overflow past 32 bits therefore shows up in the top bit and is kept. It is not lost.

The operator is used as the inner kernel of filters and transforms, where each step adds a product to the previous result. An active-low clear returns the total to zero. An active-high enable decides whether a clock edge accumulates or holds. The whole update, product plus previous total, settles within one clock period.

Top module: `mac_acc`

## Requirements
- R1: While clr_n is low at a rising clock edge, the 33-bit result acc_o becomes zero after that edge.
- R2: Clear takes priority over enable: with clr_n low and en high at the same edge, acc_o becomes zero.
- R3: At a rising edge with clr_n high and en high, acc_o becomes (acc_o + op_a * op_b) mod 2^33, with op_a and op_b taken as unsigned 16-bit values.
- R4: At a rising edge with clr_n high and en low, acc_o keeps its value, including its top bit, whatever op_a and op_b are.
- R5: Bit 32 of acc_o is the carry flip-flop. It is set when a sum carries past bit 31 and stays set through later accumulations until a further wrap past bit 32 or a clear.
- R6: With op_a = 17, op_b = 3 and en held high after clear is released, acc_o grows by exactly 51 on each clock edge.
- R7: acc_o changes only on the rising clock edge. Operand or enable changes between edges have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, priority over enable |
| en | input | 1 | Accumulate enable, active high |
| op_a | input | 16 | Unsigned multiplicand |
| op_b | input | 16 | Unsigned multiplier |
| acc_o | output | 33 | Running total: carry bit above the 32-bit sum |

## Verification
The assertions assume that clr_n, en and the operands are valid and settled at every rising edge, and that clr_n is low at the first edge so the register starts from a known value. The bench drives all inputs on the falling edge, so they are always stable when sampled. It begins each run with a clear. Random operands are mixed with all-ones operands to drive the sum past bit 31 and bit 32. Random enable and clear patterns check the hold and priority cases.

// File: rtl/mac_acc.sv
module mac_acc #(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              en,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic [2*OP_W:0]   acc_o
);
  localparam int PW = 2*OP_W;
  localparam int AW = PW + 1;
  localparam int GW = 4;
  localparam int NG = (AW + GW - 1) / GW;
  localparam int XW = NG * GW;

  logic [PW-1:0] prod;
  logic [PW-1:0] sum_q;
  logic          cy_q;
  logic [AW-1:0] nxt;

  assign prod = op_a * op_b;

  logic [XW-1:0] xa, xb, xs;
  logic [XW-1:0] g, p;
  logic [NG:0]   gc;

  assign xa = XW'({cy_q, sum_q});
  assign xb = XW'(prod);
  assign g  = xa & xb;
  assign p  = xa ^ xb;
  assign gc[0] = 1'b0;

  for (genvar k = 0; k < NG; k++) begin : g_blk
    logic [GW:0] c;
    logic        bg, bp;
    assign c[0] = gc[k];
    for (genvar i = 0; i < GW; i++) begin : g_bit
      assign c[i+1] = g[k*GW+i] | (p[k*GW+i] & c[i]);
      assign xs[k*GW+i] = p[k*GW+i] ^ c[i];
    end
    assign bp = &p[k*GW +: GW];
    assign bg = g[k*GW+3] | (p[k*GW+3] & g[k*GW+2]) |
                (p[k*GW+3] & p[k*GW+2] & g[k*GW+1]) |
                (p[k*GW+3] & p[k*GW+2] & p[k*GW+1] & g[k*GW]);
    assign gc[k+1] = bg | (bp & gc[k]);
  end

  assign nxt = xs[AW-1:0];

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      sum_q <= '0;
      cy_q  <= 1'b0;
    end else if (en) begin
      sum_q <= nxt[PW-1:0];
      cy_q  <= nxt[PW];
    end
  end

  assign acc_o = {cy_q, sum_q};

  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  p_clear_r1: assert property (@(posedge clk) !clr_n |=> acc_o == '0);
  p_clr_pri_r2: assert property (@(posedge clk) (!clr_n && en) |=> acc_o == '0);
  p_acc_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (seen && en) |=> acc_o == AW'($past(acc_o) + AW'($past(op_a) * $past(op_b))));
  p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (seen && !en) |=> $stable(acc_o));
  p_carry_keep_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (seen && acc_o[PW] && !en) |=> acc_o[PW]);
endmodule

// File: tb/tb_mac_acc.sv
module tb_mac_acc;
  logic clk = 0, clr_n = 0, en = 0;
  logic [15:0] op_a = 0, op_b = 0;
  logic [32:0] acc_o;
  logic [32:0] model = 0;
  int tests = 0, fails = 0;

  mac_acc dut (.clk, .clr_n, .en, .op_a, .op_b, .acc_o);

  always #5 clk = ~clk;

  function automatic logic [32:0] step(logic [32:0] m, logic c, logic e,
                                       logic [15:0] a, logic [15:0] b);
    if (!c) return '0;
    if (e) return m + 33'(32'(a) * 32'(b));
    return m;
  endfunction

  task automatic check(string req, logic [32:0] exp);
    tests++;
    if (acc_o !== exp) begin
      fails++;
      $display("FAIL %s: acc_o=%0h expected=%0h", req, acc_o, exp);
    end
  endtask

  task automatic cyc(logic c, logic e, logic [15:0] a, logic [15:0] b, string req);
    clr_n = c; en = e; op_a = a; op_b = b;
    model = step(model, c, e, a, b);
    @(posedge clk); @(negedge clk);
    check(req, model);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: acc_o=%0h expected=done", acc_o);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    cyc(0, 0, 0, 0, "R1");
    cyc(0, 1, 16'hFFFF, 16'hFFFF, "R2");
    for (int i = 0; i < 6; i++) begin
      cyc(1, 1, 17, 3, "R6");
      tests++;
      if (acc_o !== 33'(51*(i+1))) begin
        fails++;
        $display("FAIL R6: acc_o=%0d expected=%0d", acc_o, 51*(i+1));
      end
    end
    cyc(1, 0, 16'hFFFF, 16'hFFFF, "R4");
    clr_n = 1; en = 1; op_a = 16'hFFFF; op_b = 16'hFFFF;
    #2; op_a = 0; en = 0; #2;
    check("R7", model);
    @(negedge clk);
    cyc(0, 0, 0, 0, "R1");
    for (int i = 0; i < 3; i++) cyc(1, 1, 16'hFFFF, 16'hFFFF, "R5");
    tests++;
    if (acc_o[32] !== 1'b0) begin
      fails++;
      $display("FAIL R5: acc_o[32]=%0b expected=0", acc_o[32]);
    end
    cyc(1, 1, 16'hFFFF, 16'hFFFF, "R5");
    cyc(1, 0, 5, 7, "R4");
    tests++;
    if (acc_o[32] !== 1'b1) begin
      fails++;
      $display("FAIL R5: acc_o[32]=%0b expected=1", acc_o[32]);
    end
    for (int i = 0; i < 600; i++) cyc(1, 1, 16'hFFFF, 16'hFFFF, "R5");
    for (int i = 0; i < 3000; i++) begin
      logic c, e;
      c = ($urandom % 20) != 0;
      e = ($urandom % 4) != 0;
      cyc(c, e, 16'($urandom), 16'($urandom), "R3");
    end
    cyc(0, 1, 1, 1, "R2");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule